// File: doc/BRIEF.md
# Line Error Counter Bank

This block keeps four 16-bit error tallies for a line receiver: framing errors (index 0), CRC errors (index 1), code violations (index 2) and errored blocks (index 3). An upstream detector drives a one-cycle strobe for each event. A separate timebase supplies a one-second pulse. Software reads the tallies through an 8-bit register port.

Two capture schemes are available, and a control bit picks one. In manual scheme, software raises a per-counter freeze bit. The rising edge of that bit snapshots the live tally into a holding register and zeroes the live tally. The tally then stays still until the bit drops. In automatic scheme, every one-second pulse snapshots all four tallies and zeroes them at once. The pulse also sets a sticky interrupt and starts a busy window of programmable length, during which software should not read.

A 16-bit value is read as two bytes. The low byte must be read first. That read parks the high byte in a shadow register, so the pair stays coherent even if a new snapshot lands between the two reads.

Top module: `line_err_bank`

## Requirements
- R1: After reset, every live tally and holding register is 0, CTRL (addr 0), FREEZE (addr 1) and STATUS (addr 2) read 0, SETTLE (addr 3) reads 4, and `irq` and `busy` are low.
- R2: With CTRL bit 0 set (automatic), a `tick` pulse copies each live tally into its holding register and zeroes the live tally. Holding register i is read at addr 8+2i (low byte) and 9+2i (high byte).
- R3: An `inc` strobe in the same cycle as an automatic snapshot counts into the new period, so the live tally restarts at 1.
- R4: A tally stops at 0xFFFF and does not wrap.
- R5: In manual scheme (CTRL bit 0 clear), a tally whose FREEZE bit (bit i of addr 1) is high ignores its strobes.
- R6: In manual scheme, a 0-to-1 change of FREEZE bit i copies live tally i into holding register i and zeroes the tally. A strobe in that same cycle is dropped. Rewriting 1 onto a bit that is already high captures nothing.
- R7: In manual scheme, `tick` has no effect (no snapshot, no `irq`, no `busy`). In automatic scheme, FREEZE bits neither stop counting nor capture.
- R8: A low-byte read loads the high byte of the same holding register into a shadow. A high-byte read returns that shadow, even if the holding register has changed since.
- R9: `irq` (STATUS bit 0) is set by an automatic snapshot and stays set until a write to STATUS with bit 0 = 1. Writing 0 to that bit leaves it set.
- R10: After an automatic snapshot, `busy` (also STATUS bit 1) is high for exactly SETTLE cycles, starting with the cycle after the `tick` edge.
- R11: `rdata` shows the addressed byte in the cycle after `rd_en`, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inc | input | 4 | Per-tally error strobes (0 framing, 1 CRC, 2 code violation, 3 errored block) |
| tick | input | 1 | One-second pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq | output | 1 | Sticky one-second interrupt |
| busy | output | 1 | Settle window after a snapshot |

## Verification
Every result lands on the first clock edge after its stimulus. A strobe, tick or write that is driven at a falling edge shows its effect at the next falling edge. Read data is due one cycle after `rd_en`. The bench drives and samples only at falling edges, so each check looks at the half-cycle right after the edge that caused the result. It measures the busy window by counting the falling edges at which `busy` is high, starting at the first falling edge after the tick.

// File: rtl/line_err_bank.sv
module line_err_bank #(
  parameter int NCNT       = 4,
  parameter int CW         = 16,
  parameter int AW         = 4,
  parameter int SW         = 8,
  parameter int SETTLE_RST = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCNT-1:0] inc,
  input  logic            tick,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            irq,
  output logic            busy
);
  localparam int IW = (NCNT > 1) ? $clog2(NCNT) : 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_FRZ  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [AW-1:0] A_SETL = AW'(3);
  localparam logic [AW-1:0] A_CNT  = AW'(8);

  logic            mode_q, irq_q;
  logic [NCNT-1:0] frz_q;
  logic [SW-1:0]   settle_q, busy_q;
  logic [7:0]      shadow_q, rdata_q;
  logic [CW-1:0]   cnt_q  [NCNT];
  logic [CW-1:0]   hold_q [NCNT];

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_frz  = wr_en && addr == A_FRZ;
  wire wr_stat = wr_en && addr == A_STAT;
  wire wr_setl = wr_en && addr == A_SETL;
  wire latch   = mode_q && tick;

  wire [NCNT-1:0] frz_next = wr_frz ? wdata[NCNT-1:0] : frz_q;
  wire [NCNT-1:0] frz_rise = frz_next & ~frz_q & {NCNT{~mode_q}};

  wire [AW-1:0] off    = addr - A_CNT;
  wire [IW-1:0] sel    = off[IW:1];
  wire          in_cnt = addr >= A_CNT && off < AW'(2 * NCNT);

  assign rdata = rdata_q;
  assign irq   = irq_q;
  assign busy  = busy_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      frz_q    <= '0;
      settle_q <= SW'(SETTLE_RST);
    end else begin
      if (wr_ctrl) mode_q <= wdata[0];
      frz_q <= frz_next;
      if (wr_setl) settle_q <= wdata[SW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq_q <= 1'b0;
    else if (latch)            irq_q <= 1'b1;
    else if (wr_stat && wdata[0]) irq_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             busy_q <= '0;
    else if (latch)         busy_q <= settle_q;
    else if (busy_q != '0)  busy_q <= busy_q - 1'b1;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    wire halted = ~mode_q & frz_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g]  <= '0;
        hold_q[g] <= '0;
      end else if (latch) begin
        hold_q[g] <= cnt_q[g];
        cnt_q[g]  <= CW'(inc[g]);
      end else if (frz_rise[g]) begin
        hold_q[g] <= cnt_q[g];
        cnt_q[g]  <= '0;
      end else if (inc[g] && !halted && cnt_q[g] != CMAX) begin
        cnt_q[g]  <= cnt_q[g] + 1'b1;
      end
    end

    // R2
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> hold_q[g] == $past(cnt_q[g]));
    // R3
    restart_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch && inc[g] |=> cnt_q[g] == CW'(1));
    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] == CMAX && !latch && !frz_rise[g] |=> cnt_q[g] == CMAX);
    // R5
    frozen_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q && frz_q[g] |=> $stable(cnt_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      shadow_q <= '0;
    end else if (rd_en) begin
      if (in_cnt) begin
        if (!off[0]) begin
          rdata_q  <= hold_q[sel][7:0];
          shadow_q <= hold_q[sel][CW-1:8];
        end else begin
          rdata_q  <= shadow_q;
        end
      end else begin
        case (addr)
          A_CTRL:  rdata_q <= {7'd0, mode_q};
          A_FRZ:   rdata_q <= 8'(frz_q);
          A_STAT:  rdata_q <= {6'd0, busy, irq_q};
          A_SETL:  rdata_q <= 8'(settle_q);
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !(wr_stat && wdata[0]) |=> irq_q);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch && settle_q != '0 |=> busy);
  // R7
  manual_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && tick && !irq_q |=> !irq_q);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: tb/tb_line_err_bank.sv
module tb_line_err_bank;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [3:0] inc = 0, addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, busy;
  int checks = 0, errors = 0;
  bit done = 0;

  line_err_bank dut (.clk(clk), .rst_n(rst_n), .inc(inc), .tick(tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .busy(busy));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rd16(input int i, output int v);
    logic [7:0] lo, hi;
    rd(4'(8 + 2*i), lo);
    rd(4'(9 + 2*i), hi);
    v = {hi, lo};
  endtask

  task automatic pulse(input logic [3:0] v, input int n);
    repeat (n) begin @(negedge clk); inc = v; end
    @(negedge clk); inc = 0;
  endtask

  task automatic tick_pulse(input logic [3:0] v);
    @(negedge clk); tick = 1; inc = v;
    @(negedge clk); tick = 0; inc = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    int v, n;
    #9 rst_n = 1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 busy", busy, 0);
    rd(0, b); chk("R1 ctrl", b, 0);
    rd(1, b); chk("R1 freeze", b, 0);
    rd(2, b); chk("R1 status", b, 0);
    rd(3, b); chk("R1 settle", b, 4);
    for (int i = 0; i < 4; i++) begin rd16(i, v); chk("R1 hold", v, 0); end

    // R11: repeated reads of the same byte hold their value
    rd(3, b); chk("R11 settle read", b, 4);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", rdata, 4);

    // R7: tick in manual mode does nothing
    pulse(4'b0100, 5);
    tick_pulse(0);
    chk("R7 manual tick irq", irq, 0);
    chk("R7 manual tick busy", busy, 0);
    rd16(2, v); chk("R7 manual tick no capture", v, 0);

    // R2/R3: automatic rounds with mixed strobe patterns
    wr(0, 1);
    tick_pulse(0);             // clean period start
    wr(2, 1);
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 40; k++) begin
        logic [3:0] pat;
        for (int i = 0; i < 4; i++) pat[i] = (k < r*7 + i*3 + 1);
        @(negedge clk); inc = pat;
      end
      @(negedge clk); inc = 0;
      tick_pulse(4'b1010);
      chk("R9 irq set", irq, 1);
      for (int i = 0; i < 4; i++) begin
        n = r*7 + i*3 + 1 + ((r > 0 && (i % 2 == 1)) ? 1 : 0);
        rd16(i, v); chk("R2 R3 hold", v, n);
      end
      wr(2, 1);
    end
    tick_pulse(0);             // absorb carried counts
    wr(2, 1);

    // R9: write 0 keeps irq, write 1 clears it
    tick_pulse(0);
    wr(2, 0); chk("R9 write0 keeps", irq, 1);
    wr(2, 1); chk("R9 write1 clears", irq, 0);

    // R10: busy window length over several settle values
    for (int s = 0; s < 8; s += 3) begin
      wr(3, 8'(s));
      tick_pulse(0);
      n = 0;
      while (busy && n < 300) begin n++; @(negedge clk); end
      chk("R10 busy length", n, s);
    end
    wr(3, 4);
    tick_pulse(0);
    rd(2, b); chk("R10 status busy bit", b[1], 1);
    wr(2, 1);

    // R7: freeze bits ignored in automatic mode
    wr(1, 8'b0001);
    pulse(4'b0001, 9);
    rd16(0, v); chk("R7 auto freeze no capture", v, 0);
    tick_pulse(0);
    rd16(0, v); chk("R7 auto freeze counts", v, 9);
    wr(1, 0);

    // R8: shadow keeps the high byte across a new snapshot
    pulse(4'b0100, 300);
    tick_pulse(0);
    rd(4'd12, b); chk("R8 low byte", b, 8'h2C);
    pulse(4'b0100, 700);
    tick_pulse(0);
    rd(4'd13, b); chk("R8 shadow high", b, 8'h01);
    rd16(2, v); chk("R8 fresh pair", v, 700);

    // R4: saturation
    pulse(4'b1000, 70000);
    tick_pulse(0);
    rd16(3, v); chk("R4 saturate", v, 16'hFFFF);
    wr(2, 1);

    // R5/R6: manual freeze and clear
    tick_pulse(0);
    wr(0, 0);
    pulse(4'b0010, 10);
    wr(1, 8'b0010);
    rd16(1, v); chk("R6 capture on rise", v, 10);
    pulse(4'b0010, 5);
    wr(1, 8'b0010);
    rd16(1, v); chk("R6 no capture when already high", v, 10);
    wr(1, 0);
    rd16(1, v); chk("R6 no capture on fall", v, 10);
    pulse(4'b0010, 3);
    @(negedge clk); wr_en = 1; addr = 1; wdata = 8'b0010; inc = 4'b0010;
    @(negedge clk); wr_en = 0; inc = 0;
    rd16(1, v); chk("R5 frozen then cleared", v, 3);
    wr(1, 0);
    pulse(4'b0010, 2);
    wr(1, 8'b0010);
    rd16(1, v); chk("R6 strobe on rise dropped", v, 2);
    rd(1, b); chk("R11 freeze readback", b, 8'b0010);

    finish_run();
  end
endmodule